// File: doc/BRIEF.md
# Dual-Space I2C Target Controller

This block is the target side of an I2C bus. It answers two device IDs and serves a separate address space behind each one. The memory space is a byte-wide array selected by a two-byte address, sent high byte first. The register space is a bank of special-function registers selected by a single address byte. Both spaces are reached through simple synchronous ports: a read strobe returns data on the next clock, and a write strobe stores the data on the same clock.

SCL and SDA are oversampled by the system clock and passed through synchronisers. Start, Stop and repeated Start are detected as SDA edges while SCL is high. The block keeps a separate auto-incrementing pointer for each space. A write transfer always carries a full address phase. A read with no address phase continues from the current pointer of the selected space. A selective read loads the pointer with an aborted write and then issues a repeated Start followed by a read. The target only pulls SDA low, through an open-drain enable, and it changes that enable only while SCL is low.

Top module: `i2c_dual_target`

## Requirements
- R1: A transfer to the memory ID (default 7'h50) with R/W = 0 is acknowledged. It takes two address bytes, high byte first. Each later data byte is stored at the pointer, and the pointer then advances by one.
- R2: A transfer to the register ID (default 7'h68) is acknowledged and takes one address byte, after which data bytes are stored from that register address upward.
- R3: Loading or advancing the register pointer never changes the memory pointer, and the reverse also holds. A memory read after register traffic resumes where the last memory access stopped.
- R4: A read with no address phase (ID byte with bit 0 = 1 right after a Start) returns data from the current pointer of that space. Every byte sent advances the pointer.
- R5: A write-mode ID and its address bytes, followed by a repeated Start and a read-mode ID, return data starting at the newly loaded address. No data byte is written.
- R6: The memory pointer wraps from the top of the array (2**MEM_AW-1) to address 0. High-byte address bits above the array width are dropped.
- R7: A device ID matching neither space is not acknowledged. The transfer that follows causes no write and leaves both pointers unchanged.
- R8: On a Stop, and on a Start that interrupts a transfer, the target releases SDA and returns to idle. A read ends when the master sends no acknowledge, and the Stop that follows starts no further access. An address-only write stores nothing.
- R9: In a read, the target drives the first data bit (MSB first) during the SCL low phase that follows the acknowledge of the ID byte.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released and no read or write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| mem_re | output | 1 | Memory read strobe, data due next clock |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory address (memory pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| reg_re | output | 1 | Register read strobe, data due next clock |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | REG_AW | Register address (register pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data |

## Verification
The hardest state to reach is one where the two pointers have drifted apart through interleaved traffic. The memory pointer must be partway through a block when register reads move the other pointer, and then a bare current-address memory read must pick up exactly where it stopped. The bench builds this with a selective memory read that ends early, then a selective register read of several bytes, then current-address reads of both spaces. The expected bytes come from the bench's own model of the two arrays. Wrap-around is reached by loading address 0x07FF and reading across the top of the array. A read is then resumed to confirm where the pointer landed.

// File: rtl/i2c_dual_pkg.sv
// Shared types for the dual-space I2C target.
// Assumes: only the target modules import it.
package i2c_dual_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVID,
        ST_ACK_ID,
        ST_ADDR,
        ST_ACK_ADR,
        ST_WDATA,
        ST_ACK_DAT,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic {
        SP_MEM = 1'b0,
        SP_REG = 1'b1
    } space_e;

endpackage

// File: rtl/i2c_dual_sync.sv
// Synchronises SCL/SDA to clk and flags SCL edges and Start/Stop conditions.
// Assumes: clk is at least ~8x faster than SCL; lines idle high.
module i2c_dual_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_p;
    logic                   sda_p;

    // Shift the raw lines through the synchroniser chains and keep last values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_p     <= scl_chain[SYNC_STAGES-1];
            sda_p     <= sda_chain[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode from the synchronised samples.
    always_comb begin
        scl_hi    = scl_chain[SYNC_STAGES-1];
        sda_s     = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_hi & ~scl_p;
        scl_fall  = ~scl_hi & scl_p;
        start_det = scl_hi & scl_p & sda_p & ~sda_s;
        stop_det  = scl_hi & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_dual_ptr.sv
// Holds the two independent address pointers (memory and register space).
// Assumes: 8 < MEM_AW <= 16, REG_AW <= 8; one load or increment per space per clock.
module i2c_dual_ptr #(
    parameter int MEM_AW = 11,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              ld_reg,
    input  logic              inc_mem,
    input  logic              inc_reg,
    input  logic [7:0]        byte_in,
    output logic [MEM_AW-1:0] mem_ptr,
    output logic [REG_AW-1:0] reg_ptr
);
    localparam int HI_W = MEM_AW - 8;

    // Memory pointer: high byte, low byte, or +1 with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       mem_ptr <= '0;
        else if (ld_hi)   mem_ptr <= {byte_in[HI_W-1:0], mem_ptr[7:0]};
        else if (ld_lo)   mem_ptr <= {mem_ptr[MEM_AW-1:8], byte_in};
        else if (inc_mem) mem_ptr <= mem_ptr + 1'b1;
    end

    // Register pointer: single-byte load or +1.
    always_ff @(posedge clk) begin
        if (!rst_n)       reg_ptr <= '0;
        else if (ld_reg)  reg_ptr <= byte_in[REG_AW-1:0];
        else if (inc_reg) reg_ptr <= reg_ptr + 1'b1;
    end

    // Register-space activity must leave the memory pointer alone (R3).
    assert_reg_keeps_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_hi && !ld_lo && !inc_mem) |=> $stable(mem_ptr));

    // Memory-space activity must leave the register pointer alone (R3).
    assert_mem_keeps_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_reg && !inc_reg) |=> $stable(reg_ptr));

    // Advancing from the last location lands on location 0 (R6).
    assert_mem_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_mem && !ld_hi && !ld_lo && (&mem_ptr)) |=> (mem_ptr == '0));
endmodule

// File: rtl/i2c_dual_fsm.sv
// Bit/byte protocol engine: ID match, address phase, write data, read data, acks.
// Assumes: edge/condition flags from i2c_dual_sync; read data valid two clocks after acc_rd is set.
module i2c_dual_fsm
    import i2c_dual_pkg::*;
#(
    parameter logic [6:0] MEM_ID = 7'h50,
    parameter logic [6:0] REG_ID = 7'h68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_hi,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output space_e     space,
    output logic       acc_rd,
    output logic       acc_wr,
    output logic       ld_hi,
    output logic       ld_lo,
    output logic       ld_reg,
    output logic [7:0] byte_q
);
    tgt_state_e state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       rw;
    logic       addr_last;
    logic       ack_ok;
    logic       rd_pend;

    // Protocol sequencer: reacts to Stop, Start, SCL rise (sample) and SCL fall (drive).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            rw        <= 1'b0;
            addr_last <= 1'b0;
            ack_ok    <= 1'b0;
            rd_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            space     <= SP_MEM;
            acc_rd    <= 1'b0;
            acc_wr    <= 1'b0;
            ld_hi     <= 1'b0;
            ld_lo     <= 1'b0;
            ld_reg    <= 1'b0;
            byte_q    <= '0;
        end else begin
            acc_rd  <= 1'b0;
            acc_wr  <= 1'b0;
            ld_hi   <= 1'b0;
            ld_lo   <= 1'b0;
            ld_reg  <= 1'b0;
            rd_pend <= acc_rd;
            if (rd_pend) tx <= rd_data;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEVID;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    ST_DEVID, ST_ADDR, ST_WDATA: begin
                        if (bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                    ST_RACK: begin
                        ack_ok <= ~sda_s;
                        acc_rd <= ~sda_s;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_DEVID: begin
                        if (bitcnt == 4'd8) begin
                            if (shreg[7:1] == MEM_ID || shreg[7:1] == REG_ID) begin
                                space  <= (shreg[7:1] == MEM_ID) ? SP_MEM : SP_REG;
                                rw     <= shreg[0];
                                acc_rd <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_ID;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_ADR;
                        end
                    end
                    ST_WDATA: begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_DAT;
                        end
                    end
                    ST_ACK_ID: begin
                        bitcnt    <= '0;
                        addr_last <= (space == SP_REG);
                        sda_oe    <= rw & ~tx[7];
                        state     <= rw ? ST_RDATA : ST_ADDR;
                    end
                    ST_ACK_ADR: begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        byte_q <= shreg;
                        if (addr_last) begin
                            ld_lo  <= (space == SP_MEM);
                            ld_reg <= (space == SP_REG);
                            state  <= ST_WDATA;
                        end else begin
                            ld_hi     <= 1'b1;
                            addr_last <= 1'b1;
                            state     <= ST_ADDR;
                        end
                    end
                    ST_ACK_DAT: begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        byte_q <= shreg;
                        acc_wr <= 1'b1;
                        state  <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx[6];
                            tx     <= {tx[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                    ST_RACK: begin
                        bitcnt <= '0;
                        sda_oe <= ack_ok & ~tx[7];
                        state  <= ack_ok ? ST_RDATA : ST_IGNORE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // The SDA drive may only move while SCL is low (R10).
    assert_oe_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_hi);

    // A Stop always leaves SDA released (R8).
    assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // An unmatched or finished transfer never pulls SDA (R7).
    assert_ignore_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // Data is only stored during a write-mode transfer (R5).
    assert_no_write_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> !rw);
endmodule

// File: rtl/i2c_dual_target.sv
// Top: dual-ID I2C target with separate memory and register ports and pointers.
// Assumes: external storage answers a read strobe with data on the next clock.
module i2c_dual_target
    import i2c_dual_pkg::*;
#(
    parameter int         MEM_AW      = 11,
    parameter int         REG_AW      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] MEM_ID      = 7'h50,
    parameter logic [6:0] REG_ID      = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              mem_re,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              reg_re,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    logic       scl_hi, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       acc_rd, acc_wr, ld_hi, ld_lo, ld_reg;
    logic [7:0] byte_q;
    logic [7:0] rd_data;
    space_e     space;

    i2c_dual_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi(scl_hi), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_dual_fsm #(.MEM_ID(MEM_ID), .REG_ID(REG_ID)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .sda_oe(sda_oe), .space(space),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .ld_reg(ld_reg), .byte_q(byte_q)
    );

    i2c_dual_ptr #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_reg(ld_reg),
        .inc_mem((acc_rd | acc_wr) & (space == SP_MEM)),
        .inc_reg((acc_rd | acc_wr) & (space == SP_REG)),
        .byte_in(byte_q), .mem_ptr(mem_addr), .reg_ptr(reg_addr)
    );

    // Route access strobes and data to the space selected by the last matched ID.
    always_comb begin
        mem_re    = acc_rd & (space == SP_MEM);
        mem_we    = acc_wr & (space == SP_MEM);
        reg_re    = acc_rd & (space == SP_REG);
        reg_we    = acc_wr & (space == SP_REG);
        mem_wdata = byte_q;
        reg_wdata = byte_q;
        rd_data   = (space == SP_MEM) ? mem_rdata : reg_rdata;
    end

    // Only one space is touched per clock (R3).
    assert_one_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((mem_re || mem_we) && (reg_re || reg_we)));
endmodule

// File: tb/i2c_dual_target_bench.sv
module i2c_dual_target_bench;
    localparam int         QP     = 10;
    localparam logic [6:0] ID_MEM = 7'h50;
    localparam logic [6:0] ID_REG = 7'h68;
    localparam logic [6:0] ID_BAD = 7'h33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_bus;
    logic        sda_oe, mem_re, mem_we, reg_re, reg_we;
    logic [10:0] mem_addr;
    logic [7:0]  reg_addr, mem_wdata, reg_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  reg_rdata = 8'h00;
    logic [7:0]  mem_m [0:2047];
    logic [7:0]  reg_m [0:255];
    logic [7:0]  got [0:7];
    int          checks = 0, fails = 0, wr_count = 0, bad_edges = 0;
    logic        prev_oe = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;
    assign sda_bus = ~(m_low | sda_oe);

    i2c_dual_target u_i2c_dual_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .reg_re(reg_re), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] pat_m(int a); return 8'((a * 7 + 3) & 255); endfunction
    function automatic logic [7:0] pat_r(int a); return 8'(a ^ 8'h5C); endfunction

    // Storage model with one-clock read latency, plus write and SDA-edge monitors.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_m[mem_addr];
        if (mem_we) mem_m[mem_addr] <= mem_wdata;
        if (reg_re) reg_rdata <= reg_m[reg_addr];
        if (reg_we) reg_m[reg_addr] <= reg_wdata;
        if (mem_we || reg_we) wr_count <= wr_count + 1;
        prev_oe <= sda_oe;
        if (sda_oe != prev_oe && scl) bad_edges <= bad_edges + 1;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        m_low = 1'b0; wq(QP); scl = 1'b1; wq(QP); m_low = 1'b1; wq(QP); scl = 1'b0; wq(QP);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(QP); scl = 1'b1; wq(QP); m_low = 1'b0; wq(QP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(QP); scl = 1'b1; wq(2 * QP); scl = 1'b0; wq(QP);
        end
        m_low = 1'b0; wq(QP); scl = 1'b1; wq(QP); ack = ~sda_bus; wq(QP); scl = 1'b0; wq(QP);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(QP); scl = 1'b1; wq(QP); b[i] = sda_bus; wq(QP); scl = 1'b0; wq(QP);
        end
        m_low = give_ack; wq(QP); scl = 1'b1; wq(2 * QP); scl = 1'b0; wq(QP);
        m_low = 1'b0;
    endtask

    // Start, write-mode ID and address bytes; ok is the AND of all acks.
    task automatic addr_phase(input logic [6:0] id, input logic two, input logic [15:0] a,
                              output logic ok);
        logic k;
        bus_start();
        send_byte({id, 1'b0}, k); ok = k;
        if (two) begin send_byte(a[15:8], k); ok &= k; end
        send_byte(a[7:0], k); ok &= k;
    endtask

    task automatic write_seq(input logic [6:0] id, input logic two, input logic [15:0] a,
                             input int n, input logic [31:0] d, output logic ok);
        logic k;
        addr_phase(id, two, a, ok);
        for (int i = 0; i < n; i++) begin send_byte(d[31 - 8 * i -: 8], k); ok &= k; end
        bus_stop();
    endtask

    task automatic cur_read(input logic [6:0] id, input int n, output logic ok);
        bus_start();
        send_byte({id, 1'b1}, ok);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, got[i]);
        bus_stop();
    endtask

    task automatic sel_read(input logic [6:0] id, input logic two, input logic [15:0] a,
                            input int n, output logic ok);
        logic k;
        addr_phase(id, two, a, ok);
        bus_start();
        send_byte({id, 1'b1}, k); ok &= k;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, got[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R11 sda released", sda_oe, 0);
        chk("R11 no strobes", {mem_re, mem_we, reg_re, reg_we}, 0);
    endtask

    task automatic t_mem_write();
        logic ok; int w0;
        w0 = wr_count;
        write_seq(ID_MEM, 1'b1, 16'h0123, 3, 32'hA1B2C300, ok);
        chk("R1 mem write acks", ok, 1);
        chk("R1 mem write count", wr_count - w0, 3);
        sel_read(ID_MEM, 1'b1, 16'h0123, 3, ok);
        chk("R5 selective read acks", ok, 1);
        chk("R1 R9 mem byte0", got[0], 8'hA1);
        chk("R1 mem byte1", got[1], 8'hB2);
        chk("R5 mem byte2", got[2], 8'hC3);
    endtask

    task automatic t_reg_write();
        logic ok;
        write_seq(ID_REG, 1'b0, 16'h0010, 2, 32'h5A6B0000, ok);
        chk("R2 reg write acks", ok, 1);
        sel_read(ID_REG, 1'b0, 16'h0010, 2, ok);
        chk("R2 reg byte0", got[0], 8'h5A);
        chk("R2 reg byte1", got[1], 8'h6B);
    endtask

    task automatic t_independent();
        logic ok;
        sel_read(ID_MEM, 1'b1, 16'h0123, 1, ok);
        chk("R5 mem single", got[0], 8'hA1);
        sel_read(ID_REG, 1'b0, 16'h0010, 2, ok);
        chk("R3 reg between", got[1], 8'h6B);
        cur_read(ID_MEM, 2, ok);
        chk("R4 current ack", ok, 1);
        chk("R3 mem resumes", got[0], 8'hB2);
        chk("R4 mem advances", got[1], 8'hC3);
        cur_read(ID_REG, 1, ok);
        chk("R4 reg current", got[0], pat_r(8'h12));
    endtask

    task automatic t_wrap();
        logic ok;
        write_seq(ID_MEM, 1'b1, 16'hFFFF, 2, 32'h11220000, ok);
        sel_read(ID_MEM, 1'b1, 16'h07FF, 2, ok);
        chk("R6 top byte", got[0], 8'h11);
        chk("R6 wrapped byte", got[1], 8'h22);
        cur_read(ID_MEM, 1, ok);
        chk("R6 ptr after wrap", got[0], pat_m(1));
    endtask

    task automatic t_bad_id();
        logic k; logic ok; int w0;
        w0 = wr_count;
        bus_start();
        send_byte({ID_BAD, 1'b0}, k);
        chk("R7 bad id nack", k, 0);
        send_byte(8'h00, k);
        send_byte(8'h55, k);
        chk("R7 data nack", k, 0);
        bus_stop();
        chk("R7 no write", wr_count - w0, 0);
        cur_read(ID_MEM, 1, ok);
        chk("R7 mem ptr kept", got[0], pat_m(2));
    endtask

    task automatic t_release();
        logic ok; int w0;
        w0 = wr_count;
        chk("R8 released after nack stop", sda_oe, 0);
        write_seq(ID_MEM, 1'b1, 16'h0040, 0, 32'h0, ok);
        chk("R8 addr-only acks", ok, 1);
        chk("R8 addr-only stores nothing", wr_count - w0, 0);
        addr_phase(ID_REG, 1'b0, 16'h0020, ok);
        bus_start();
        send_byte({ID_BAD, 1'b1}, ok);
        chk("R8 restart to bad id nack", ok, 0);
        bus_stop();
        chk("R8 idle after restart", sda_oe, 0);
        cur_read(ID_REG, 1, ok);
        chk("R8 reg ptr from interrupted write", got[0], pat_r(8'h20));
        chk("R10 sda edges while scl high", bad_edges, 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem_m[i] = pat_m(i);
        for (int i = 0; i < 256; i++) reg_m[i] = pat_r(i);
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_mem_write();
        t_reg_write();
        t_independent();
        t_wrap();
        t_bad_id();
        t_release();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule